// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control sequencer of a successive-approximation converter. It runs on the CPU clock. A resettable prescaler produces a single-cycle ADC tick once per ADC clock period. The sequencer counts these ticks to place three one-cycle pulses: a channel/reference select update, a sample-and-hold strobe and a conversion-complete strobe. At completion it captures the word from the comparator/SAR stub into a result register and raises a sticky completion flag.

A conversion starts in one of two ways. Software can raise a start request, or, in auto-trigger mode, a rising edge on the trigger input starts it. The trigger edge first passes three CPU cycles of synchronisation and then restarts the prescaler, so the time from the edge to the sample is fixed. In free-running mode the next conversion follows the previous one with no gap for as long as the start bit stays set. The first conversion after the block is enabled is longer (25 ADC ticks instead of 13), because the analog front end has to settle. Dropping the enable aborts any conversion in progress and arms the long path again.

The sequencer has three states. `S_OFF` is the disabled state. `S_IDLE` is enabled but not converting. `S_CONV` is converting. Its transitions are:
- OFF-to-IDLE when the enable is high.
- IDLE-to-CONV on an accepted software start or an accepted trigger.
- CONV-to-IDLE at completion when no free-running restart follows.
- CONV-to-CONV at completion when a free-running restart follows.
- Any-to-OFF when the enable is low.

Top module: `adcseq_ctrl`

## Requirements
- R1: While enabled, the ADC tick period is 2^e CPU cycles, where e = `presc_sel` and a value of 0 is treated as 1 (selections 0 and 1 both give 2; 7 gives 128). Two ticks are never adjacent.
- R2: In a normal conversion, `mux_upd` is pulsed on the 1st ADC tick of the conversion, `sample_hold` on the 2nd tick and `conv_done` on the 13th tick.
- R3: In the first conversion after enable, `sample_hold` comes on the 14th tick and `conv_done` on the 25th tick. Every later conversion is normal.
- R4: A `start_set` pulse in `S_IDLE` sets `start_busy` and begins a conversion whose first tick is the next prescaler tick. Unless a free-running restart follows, `start_busy` clears when the conversion completes and the sequencer returns to `S_IDLE`.
- R5: In the cycle `conv_done` is high, `result` holds the value `sar_data` had at the completing edge and `flag` is 1. `result` changes at no other time. After reset, `result` and `flag` are 0.
- R6: `flag` stays 1 until `flag_clr` is pulsed. If a completion and a clear fall on the same edge, the completion wins.
- R7: With `auto_mode` high in `S_IDLE`, suppose a rising `trig_in` is first sampled at CPU edge E0. The prescaler then restarts at edge E3, `mux_upd` appears after edge E3+D and `sample_hold` after edge E3+2D, where D is the tick period.
- R8: A trigger edge has no effect while a conversion is in progress (the conversion timing is unchanged and no conversion follows), when `auto_mode` is low, or while the block is disabled.
- R9: With `free_mode` high and `start_busy` set at completion, `mux_upd` of the next conversion comes exactly one tick period after `conv_done`. After `start_clr`, the running conversion completes and no further conversion starts.
- R10: When `enable` is low, the sequencer enters `S_OFF` and `start_busy` clears at the next edge. An aborted conversion produces no `conv_done` and leaves `result` unchanged. The next conversion is a first (long) conversion.
- R11: At most one of `mux_upd`, `sample_hold` and `conv_done` is high in any cycle, and each is one cycle wide.
- R12: A `start_set` pulse while `enable` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low aborts and re-arms the long first conversion |
| start_set | input | 1 | One-cycle software request to set the start bit |
| start_clr | input | 1 | One-cycle software request to clear the start bit |
| auto_mode | input | 1 | Accept rising edges of `trig_in` as conversion starts |
| free_mode | input | 1 | Restart directly after each completion while the start bit is set |
| trig_in | input | 1 | Asynchronous auto-trigger source |
| presc_sel | input | SEL_W | Prescaler exponent select |
| flag_clr | input | 1 | Write-one-to-clear for `flag` |
| sar_data | input | RES_W | Comparator/SAR result stub, sampled at completion |
| start_busy | output | 1 | Start bit (conversion requested or in progress) |
| mux_upd | output | 1 | Channel and reference select update pulse |
| sample_hold | output | 1 | Sample-and-hold strobe |
| conv_done | output | 1 | Conversion complete pulse |
| result | output | RES_W | Latched conversion result |
| flag | output | 1 | Sticky completion flag |

## Verification
The assertions assume the following about the inputs:
- `presc_sel` changes only while `enable` is low, so the prescaler count never runs past the new limit.
- `trig_in`, although asynchronous, stays high long enough for the three-stage synchroniser to see it.

The stimulus keeps to both. It changes the selection only after `enable` has dropped, and it holds every trigger for many CPU cycles. It drives all inputs at the falling edge. It sweeps all eight prescaler selections with a long conversion followed by a short one, and it takes the trigger-to-sample latency against the tick period over five selections.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_IDLE = 2'd1,
        S_CONV = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adcseq_prescaler.sv
module adcseq_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        int unsigned e;
        e   = (sel == '0) ? 1 : int'(sel);
        lim = CNT_W'((64'd1 << e) - 64'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clr) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && !clr && (cnt == lim);

    // Ticks are at least two CPU cycles apart.
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // A cleared prescaler cannot tick in the next cycle.
    assert_clr_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);

endmodule

// File: rtl/adcseq_trig_sync.sv
module adcseq_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe[0] <= 1'b0;
        end else begin
            pipe[0] <= din;
        end
    end

    for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[i] <= 1'b0;
            end else begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt <= 1'b0;
        end else begin
            evt <= pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
        end
    end

    if (SYNC_STAGES == 2) begin : g_chk
        // An event reflects the input as sampled three edges earlier.
        assert_evt_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
            evt |-> $past(din, 3));
    end

    assert_evt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int NORM_LEN  = 13,
    parameter int NORM_SH   = 2,
    parameter int FIRST_LEN = 25,
    parameter int FIRST_SH  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic             auto_mode,
    input  logic             free_mode,
    input  logic             trig_evt,
    input  logic             tick,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] sar_data,
    output logic             presc_clr,
    output logic             start_busy,
    output logic             mux_upd,
    output logic             sample_hold,
    output logic             conv_done,
    output logic [RES_W-1:0] result,
    output logic             flag
);
    localparam int K_W = $clog2(FIRST_LEN + 1);

    seq_state_t     state, nstate;
    logic [K_W-1:0] k, k_nx, len, shk;
    logic           first;
    logic           go_trig, go_sw, last, keep_start, restart;

    always_comb begin
        go_trig    = (state == S_IDLE) && enable && auto_mode && trig_evt;
        go_sw      = (state == S_IDLE) && enable && start_set;
        presc_clr  = go_trig;
        k_nx       = k + 1'b1;
        len        = first ? K_W'(FIRST_LEN) : K_W'(NORM_LEN);
        shk        = first ? K_W'(FIRST_SH)  : K_W'(NORM_SH);
        last       = (state == S_CONV) && enable && tick && (k_nx == len);
        keep_start = start_busy && !start_clr;
        restart    = last && free_mode && keep_start;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_OFF:  if (enable) nstate = S_IDLE;
            S_IDLE: begin
                if (!enable)                nstate = S_OFF;
                else if (go_trig || go_sw)  nstate = S_CONV;
            end
            S_CONV: begin
                if (!enable)                nstate = S_OFF;
                else if (last && !restart)  nstate = S_IDLE;
            end
            default: nstate = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k           <= '0;
            first       <= 1'b1;
            start_busy  <= 1'b0;
            mux_upd     <= 1'b0;
            sample_hold <= 1'b0;
            conv_done   <= 1'b0;
            result      <= '0;
        end else begin
            mux_upd     <= 1'b0;
            sample_hold <= 1'b0;
            conv_done   <= 1'b0;
            if (!enable) begin
                k          <= '0;
                first      <= 1'b1;
                start_busy <= 1'b0;
            end else begin
                unique case (state)
                    S_OFF: begin
                        k <= '0;
                    end
                    S_IDLE: begin
                        k <= '0;
                        if (go_trig || go_sw) start_busy <= 1'b1;
                        else if (start_clr)   start_busy <= 1'b0;
                    end
                    S_CONV: begin
                        if (start_clr) start_busy <= 1'b0;
                        if (tick) begin
                            k <= k_nx;
                            if (k_nx == K_W'(1)) mux_upd     <= 1'b1;
                            if (k_nx == shk)     sample_hold <= 1'b1;
                            if (last) begin
                                conv_done <= 1'b1;
                                result    <= sar_data;
                                first     <= 1'b0;
                                k         <= '0;
                                if (!restart) start_busy <= 1'b0;
                            end
                        end
                    end
                    default: k <= '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (last)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mux_upd, sample_hold, conv_done}));

    assert_done_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    assert_mux_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mux_upd |=> !mux_upd);

    assert_off_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == S_OFF) && !start_busy);

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !conv_done);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |-> $stable(result));

    assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> flag);

    assert_restart_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (start_busy == (state == S_CONV)));

    assert_off_idle_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF) |-> !start_busy);

    assert_busy_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CONV) |-> !presc_clr);

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl #(
    parameter int SEL_W       = 3,
    parameter int RES_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int NORM_LEN    = 13,
    parameter int NORM_SH     = 2,
    parameter int FIRST_LEN   = 25,
    parameter int FIRST_SH    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic             auto_mode,
    input  logic             free_mode,
    input  logic             trig_in,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] sar_data,
    output logic             start_busy,
    output logic             mux_upd,
    output logic             sample_hold,
    output logic             conv_done,
    output logic [RES_W-1:0] result,
    output logic             flag
);
    logic tick, presc_clr, trig_evt;

    adcseq_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .clr   (presc_clr),
        .sel   (presc_sel),
        .tick  (tick)
    );

    adcseq_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_in),
        .evt   (trig_evt)
    );

    adcseq_fsm #(
        .RES_W     (RES_W),
        .NORM_LEN  (NORM_LEN),
        .NORM_SH   (NORM_SH),
        .FIRST_LEN (FIRST_LEN),
        .FIRST_SH  (FIRST_SH)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .start_set   (start_set),
        .start_clr   (start_clr),
        .auto_mode   (auto_mode),
        .free_mode   (free_mode),
        .trig_evt    (trig_evt),
        .tick        (tick),
        .flag_clr    (flag_clr),
        .sar_data    (sar_data),
        .presc_clr   (presc_clr),
        .start_busy  (start_busy),
        .mux_upd     (mux_upd),
        .sample_hold (sample_hold),
        .conv_done   (conv_done),
        .result      (result),
        .flag        (flag)
    );

endmodule

// File: tb/adcseq_ctrl_tb.sv
`timescale 1ns/1ps
module adcseq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       enable = 0, start_set = 0, start_clr = 0, auto_mode = 0;
    logic       free_mode = 0, trig_in = 0, flag_clr = 0;
    logic [2:0] presc_sel = 0;
    logic [9:0] sar_data = 0;
    logic       start_busy, mux_upd, sample_hold, conv_done, flag;
    logic [9:0] result;

    int checks = 0, errors = 0;
    int cyc = 0;
    int t_mux = 0, t_sh = 0, t_done = 0, n_mux = 0, n_sh = 0, n_done = 0, multi = 0;

    adcseq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_set(start_set),
        .start_clr(start_clr), .auto_mode(auto_mode), .free_mode(free_mode),
        .trig_in(trig_in), .presc_sel(presc_sel), .flag_clr(flag_clr),
        .sar_data(sar_data), .start_busy(start_busy), .mux_upd(mux_upd),
        .sample_hold(sample_hold), .conv_done(conv_done), .result(result),
        .flag(flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            if (mux_upd)     begin t_mux  = cyc; n_mux++;  end
            if (sample_hold) begin t_sh   = cyc; n_sh++;   end
            if (conv_done)   begin t_done = cyc; n_done++; end
            if (int'(mux_upd) + int'(sample_hold) + int'(conv_done) > 1) multi++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_set = 1'b1; step(1); start_set = 1'b0;
    endtask

    task automatic pulse_fclr();
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    endtask

    task automatic wait_done(input int lim, input string req);
        int n0 = n_done;
        int i = 0;
        while (n_done == n0 && i < lim) begin step(1); i++; end
        chk(n_done != n0, req, i, lim);
    endtask

    task automatic wait_mux(input int lim, input string req);
        int n0 = n_mux;
        int i = 0;
        while (n_mux == n0 && i < lim) begin step(1); i++; end
        chk(n_mux != n0, req, i, lim);
    endtask

    function automatic int div_of(input int s);
        return (s < 2) ? 2 : (1 << s);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d, tc, m0, d0;
        logic [9:0] prev;
        step(4);
        rst_n = 1'b1;
        step(2);
        chk(flag == 0 && result == 0, "R5 reset", int'(result), 0);
        chk(start_busy == 0, "R4 reset", int'(start_busy), 0);

        // R12: start while disabled
        pulse_start();
        step(300);
        chk(n_mux == 0 && start_busy == 0, "R12 start ignored", n_mux, 0);

        for (int s = 0; s < 8; s++) begin
            d = div_of(s);
            presc_sel = 3'(s);
            enable = 1'b1;
            step(2);
            sar_data = 10'(37 * s + 101);
            pulse_start();
            wait_done(40 * d, "R3 first done");
            chk(t_sh - t_mux == 13 * d, "R3 first sample", t_sh - t_mux, 13 * d);
            chk(t_done - t_mux == 24 * d, "R3 first length", t_done - t_mux, 24 * d);
            chk(result == 10'(37 * s + 101), "R5 result", int'(result), 37 * s + 101);
            chk(flag == 1, "R5 flag set", int'(flag), 1);
            chk(start_busy == 0, "R4 start clears", int'(start_busy), 0);
            pulse_fclr();
            chk(flag == 0, "R6 flag clear", int'(flag), 0);

            sar_data = 10'(900 - s);
            pulse_start();
            wait_done(20 * d, "R2 done");
            chk(t_sh - t_mux == d, "R1 R2 sample tick", t_sh - t_mux, d);
            chk(t_done - t_mux == 12 * d, "R1 R2 length", t_done - t_mux, 12 * d);
            step(5);
            chk(flag == 1, "R6 sticky", int'(flag), 1);
            pulse_fclr();

            if (s <= 4) begin
                auto_mode = 1'b1;
                step(3);
                tc = cyc;
                trig_in = 1'b1;
                wait_done(20 * d + 10, "R7 auto done");
                chk(t_mux - tc == 4 + d, "R7 trigger to update", t_mux - tc, 4 + d);
                chk(t_sh - tc == 4 + 2 * d, "R7 trigger to sample", t_sh - tc, 4 + 2 * d);
                trig_in = 1'b0;
                auto_mode = 1'b0;
                step(5);
                pulse_fclr();
            end
            enable = 1'b0;
            step(2);
        end

        // R8: trigger during conversion, and with auto mode off
        presc_sel = 3'd2; d = 4;
        enable = 1'b1; auto_mode = 1'b1;
        step(2);
        pulse_start();
        step(40);
        trig_in = 1'b1;
        wait_done(40 * d, "R8 busy done");
        chk(t_done - t_mux == 24 * d, "R8 busy trigger timing", t_done - t_mux, 24 * d);
        m0 = n_mux;
        step(200);
        chk(n_mux == m0, "R8 busy trigger no start", n_mux, m0);
        trig_in = 1'b0; auto_mode = 1'b0;
        step(10);
        trig_in = 1'b1;
        step(200);
        chk(n_mux == m0 && start_busy == 0, "R8 auto off ignored", n_mux, m0);
        trig_in = 1'b0;

        // R9: free running
        enable = 1'b0; step(2);
        presc_sel = 3'd1; d = 2;
        enable = 1'b1; free_mode = 1'b1;
        step(2);
        pulse_start();
        wait_done(60 * d, "R9 first");
        wait_mux(4 * d, "R9 restart");
        chk(t_mux - t_done == d, "R9 back to back", t_mux - t_done, d);
        chk(start_busy == 1, "R9 start held", int'(start_busy), 1);
        wait_done(20 * d, "R9 second");
        chk(t_done - t_mux == 12 * d, "R9 normal length", t_done - t_mux, 12 * d);
        step(3);
        start_clr = 1'b1; step(1); start_clr = 1'b0;
        wait_done(20 * d, "R9 last");
        m0 = n_mux;
        step(100);
        chk(n_mux == m0 && start_busy == 0, "R9 stops after clear", n_mux, m0);
        free_mode = 1'b0;

        // R10: abort
        prev = result;
        d0 = n_done;
        sar_data = 10'h2AA;
        pulse_start();
        step(12);
        enable = 1'b0;
        step(1);
        chk(start_busy == 0, "R10 busy cleared", int'(start_busy), 0);
        step(200);
        chk(n_done == d0, "R10 no done", n_done, d0);
        chk(result == prev, "R10 result kept", int'(result), int'(prev));
        enable = 1'b1;
        step(2);
        pulse_start();
        wait_done(40 * d, "R10 re-armed");
        chk(t_sh - t_mux == 13 * d, "R10 R3 long again", t_sh - t_mux, 13 * d);

        chk(multi == 0, "R11 pulse overlap", multi, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule